// File: doc/BRIEF.md
# Three-Phase Inverter Voltage Model

This block stands in for a two-level, three-leg power inverter so that a motor controller can be tested in closed loop against hardware running in the fabric. It takes six gate signals (a top and a bottom switch per leg), a DC-link voltage and the three phase currents fed back from a load model. From these it works out each leg's node voltage, including the resistive drop of a conducting switch and the forward drop of a freewheeling body diode. It then reports the three line-to-line voltages.

Each input group has two possible sources. The gates have one, and the DC-link voltage with the currents form the other. Each group comes either from values a processor has written and committed with a write strobe, or straight from fabric ports. A read strobe copies the live outputs into a set of registers that a processor can read at leisure. There is deliberately no shoot-through interlock: a leg with both switches on still yields a defined voltage, and neither gate is masked. All voltages and currents are signed fixed point with 16 fractional bits.

Top module: `inv3_voltage_model`

## Requirements
- R1: While the active-low reset is held, and on the first cycle after it, every output is zero. The committed processor gate, current and DC-link values reset to zero.
- R2: All quantities are signed two's complement with 16 fractional bits (1.0 = 65536). In a leg whose top switch alone is on, the node voltage is Udc - (Ron*i >>> 16).
- R3: In a leg whose bottom switch alone is on, the node voltage is -(Ron*i >>> 16).
- R4: In a leg with both switches off and a positive current, the node is -Vf (lower diode). With a negative current the node is Udc + Vf (upper diode).
- R5: In a leg with both switches off and zero current, the node is Udc >>> 1.
- R6: In a leg with both switches on (shoot-through), the node is (Udc >>> 1) - (Ron*i >>> 16). Gating is never blocked.
- R7: When all currents are zero, no drop is applied: a leg with top on and a leg with bottom on differ by exactly Udc.
- R8: u_ab = Va - Vb, u_bc = Vb - Vc and u_ca = Vc - Va. Each is registered and shows input changes one clock later.
- R9: Gate bits are ordered [0] top a, [1] bottom a, [2] top b, [3] bottom b, [4] top c, [5] bottom c. With gate_src_cpu = 1 the committed processor gates are used; with 0 the fabric gates are used.
- R10: With iv_src_cpu = 1 the committed processor DC-link voltage and currents are used; with 0 the fabric values are used. This choice is independent of the gate source.
- R11: Processor gate values are committed only in a cycle with cpu_gate_wr high. Processor DC-link and current values are committed only in a cycle with cpu_iv_wr high. Otherwise, writes to those inputs do not change the outputs.
- R12: In a cycle with cpu_u_rd high, rd_u_* take the values u_* hold in that cycle. Otherwise rd_u_* stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_src_cpu | input | 1 | 1 = committed processor gates, 0 = fabric gates |
| iv_src_cpu | input | 1 | 1 = committed processor Udc/currents, 0 = fabric |
| cpu_gate | input | 6 | Processor gate value |
| cpu_gate_wr | input | 1 | Commit strobe for cpu_gate |
| cpu_udc | input | DW | Processor DC-link voltage |
| cpu_ia | input | DW | Processor phase a current |
| cpu_ib | input | DW | Processor phase b current |
| cpu_ic | input | DW | Processor phase c current |
| cpu_iv_wr | input | 1 | Commit strobe for processor Udc and currents |
| fab_gate | input | 6 | Fabric gate value |
| fab_udc | input | DW | Fabric DC-link voltage |
| fab_ia | input | DW | Fabric phase a current |
| fab_ib | input | DW | Fabric phase b current |
| fab_ic | input | DW | Fabric phase c current |
| cpu_u_rd | input | 1 | Capture strobe for the read registers |
| u_ab | output | DW | Live line-to-line voltage a-b |
| u_bc | output | DW | Live line-to-line voltage b-c |
| u_ca | output | DW | Live line-to-line voltage c-a |
| rd_u_ab | output | DW | Captured u_ab |
| rd_u_bc | output | DW | Captured u_bc |
| rd_u_ca | output | DW | Captured u_ca |

## Verification
On every cycle the assertions check four things: the three line voltages sum to zero, the read registers hold without a read strobe, a strobe copies the live values, and the outputs are zero right after reset. The per-leg conduction cases only show up in the bench's scenarios, compared with a behavioural model each clock. These are top or bottom drop, the diode polarity chosen by current sign, the zero-current midpoint and shoot-through. The same holds for the independence of the two source selects and the effect of the write strobes.

// File: rtl/inv3_pkg.sv
// Package: shared types for the inverter voltage model.
// Assumes legs are always three (a, b, c), two switches each.
package inv3_pkg;
    localparam int NLEG  = 3;
    localparam int NGATE = 2 * NLEG;

    // Leg conduction state, bit1 = top switch, bit0 = bottom switch.
    typedef enum logic [1:0] {
        LEG_OFF   = 2'b00,
        LEG_LOW   = 2'b01,
        LEG_HIGH  = 2'b10,
        LEG_SHORT = 2'b11
    } leg_state_e;
endpackage

// File: rtl/inv3_src_hold.sv
// Source selector with a processor holding register.
// The processor value is committed on cpu_stb; sel picks the committed
// value (1) or the fabric value (0). Assumes a synchronous active-low reset.
module inv3_src_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_cpu,
    input  logic [W-1:0] cpu_d,
    input  logic         cpu_stb,
    input  logic [W-1:0] fab_d,
    output logic [W-1:0] q
);
    logic [W-1:0] hold_q;

    // Commit the processor value only on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (cpu_stb) hold_q <= cpu_d;
    end

    // Pick the active source.
    always_comb q = sel_cpu ? hold_q : fab_d;
endmodule

// File: rtl/inv3_leg_node.sv
// One half bridge: node voltage from gate pair, DC link and phase current.
// Fixed point with FRAC fractional bits; positive current leaves the node.
// No interlock: both switches on gives a defined midpoint-minus-drop result.
module inv3_leg_node import inv3_pkg::*; #(
    parameter int                     DW    = 32,
    parameter int                     FRAC  = 16,
    parameter logic signed [DW-1:0]   RON_Q = 32'sd1966,
    parameter logic signed [DW-1:0]   VF_Q  = 32'sd52429
) (
    input  logic                 top_on,
    input  logic                 bot_on,
    input  logic signed [DW-1:0] udc,
    input  logic signed [DW-1:0] i_ph,
    output logic signed [DW-1:0] node
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;
    logic signed [DW-1:0] drop;
    logic signed [DW-1:0] half;
    leg_state_e           st;

    // Resistive drop Ron*i rescaled to the common format.
    always_comb begin
        prod = $signed({{DW{RON_Q[DW-1]}}, RON_Q}) * $signed({{DW{i_ph[DW-1]}}, i_ph});
        drop = prod[FRAC +: DW];
        half = udc >>> 1;
    end

    // Node voltage by conduction state.
    always_comb begin
        st = leg_state_e'({top_on, bot_on});
        unique case (st)
            LEG_HIGH:  node = udc - drop;
            LEG_LOW:   node = -drop;
            LEG_SHORT: node = half - drop;
            default: begin
                if (i_ph > 0)      node = -VF_Q;
                else if (i_ph < 0) node = udc + VF_Q;
                else               node = half;
            end
        endcase
    end
endmodule

// File: rtl/inv3_voltage_model.sv
// Top: three-phase inverter voltage model for controller-in-the-loop use.
// Selects gate and Udc/current sources, evaluates three legs, registers the
// line-to-line voltages and captures them on a read strobe.
// Assumes one clock domain and a synchronous active-low reset.
module inv3_voltage_model import inv3_pkg::*; #(
    parameter int                   DW    = 32,
    parameter int                   FRAC  = 16,
    parameter logic signed [DW-1:0] RON_Q = 32'sd1966,
    parameter logic signed [DW-1:0] VF_Q  = 32'sd52429
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gate_src_cpu,
    input  logic                 iv_src_cpu,
    input  logic [NGATE-1:0]     cpu_gate,
    input  logic                 cpu_gate_wr,
    input  logic signed [DW-1:0] cpu_udc,
    input  logic signed [DW-1:0] cpu_ia,
    input  logic signed [DW-1:0] cpu_ib,
    input  logic signed [DW-1:0] cpu_ic,
    input  logic                 cpu_iv_wr,
    input  logic [NGATE-1:0]     fab_gate,
    input  logic signed [DW-1:0] fab_udc,
    input  logic signed [DW-1:0] fab_ia,
    input  logic signed [DW-1:0] fab_ib,
    input  logic signed [DW-1:0] fab_ic,
    input  logic                 cpu_u_rd,
    output logic signed [DW-1:0] u_ab,
    output logic signed [DW-1:0] u_bc,
    output logic signed [DW-1:0] u_ca,
    output logic signed [DW-1:0] rd_u_ab,
    output logic signed [DW-1:0] rd_u_bc,
    output logic signed [DW-1:0] rd_u_ca
);
    localparam int IVW = (NLEG + 1) * DW;

    logic [NGATE-1:0]     gate_sel;
    logic [IVW-1:0]       iv_sel;
    logic signed [DW-1:0] udc_sel;
    logic signed [DW-1:0] node [NLEG];

    inv3_src_hold #(.W(NGATE)) u_gate_src (
        .clk(clk), .rst_n(rst_n), .sel_cpu(gate_src_cpu),
        .cpu_d(cpu_gate), .cpu_stb(cpu_gate_wr), .fab_d(fab_gate), .q(gate_sel)
    );

    inv3_src_hold #(.W(IVW)) u_iv_src (
        .clk(clk), .rst_n(rst_n), .sel_cpu(iv_src_cpu),
        .cpu_d({cpu_ic, cpu_ib, cpu_ia, cpu_udc}), .cpu_stb(cpu_iv_wr),
        .fab_d({fab_ic, fab_ib, fab_ia, fab_udc}), .q(iv_sel)
    );

    // DC-link voltage sits in the lowest slice of the selected bundle.
    always_comb udc_sel = iv_sel[DW-1:0];

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        inv3_leg_node #(.DW(DW), .FRAC(FRAC), .RON_Q(RON_Q), .VF_Q(VF_Q)) u_leg (
            .top_on(gate_sel[2*g]),
            .bot_on(gate_sel[2*g+1]),
            .udc   (udc_sel),
            .i_ph  (iv_sel[(g+1)*DW +: DW]),
            .node  (node[g])
        );
    end

    // Register the line-to-line differences.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_ab <= '0;
            u_bc <= '0;
            u_ca <= '0;
        end else begin
            u_ab <= node[0] - node[1];
            u_bc <= node[1] - node[2];
            u_ca <= node[2] - node[0];
        end
    end

    // Capture the live outputs for processor reads on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_u_ab <= '0;
            rd_u_bc <= '0;
            rd_u_ca <= '0;
        end else if (cpu_u_rd) begin
            rd_u_ab <= u_ab;
            rd_u_bc <= u_bc;
            rd_u_ca <= u_ca;
        end
    end
endmodule

// File: rtl/inv3_voltage_model_chk.sv
// Checker for the inverter voltage model, attached by bind.
// Observes only top-level ports.
module inv3_voltage_model_chk #(
    parameter int DW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cpu_u_rd,
    input logic signed [DW-1:0] u_ab,
    input logic signed [DW-1:0] u_bc,
    input logic signed [DW-1:0] u_ca,
    input logic signed [DW-1:0] rd_u_ab,
    input logic signed [DW-1:0] rd_u_bc,
    input logic signed [DW-1:0] rd_u_ca
);
    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (u_ab == 0 && u_bc == 0 && u_ca == 0 && rd_u_ab == 0 && rd_u_bc == 0 && rd_u_ca == 0)); // R1

    AST_LL_SUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n) DW'(u_ab + u_bc + u_ca) == '0); // R8

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cpu_u_rd |=> ($stable(rd_u_ab) && $stable(rd_u_bc) && $stable(rd_u_ca))); // R12

    AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) cpu_u_rd |=> (rd_u_ab == $past(u_ab) && rd_u_bc == $past(u_bc) && rd_u_ca == $past(u_ca))); // R12
endmodule

bind inv3_voltage_model inv3_voltage_model_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_u_rd(cpu_u_rd),
    .u_ab(u_ab), .u_bc(u_bc), .u_ca(u_ca),
    .rd_u_ab(rd_u_ab), .rd_u_bc(rd_u_bc), .rd_u_ca(rd_u_ca)
);

// File: tb/inv3_voltage_model_tb_top.sv
// Bench: behavioural reference model updated each rising edge, compared with
// the outputs on every falling edge, plus directed checks with fixed values.
module inv3_voltage_model_tb_top;
    localparam int  ONE  = 65536;
    localparam logic signed [31:0] RON = 32'sd1966;
    localparam logic signed [31:0] VF  = 32'sd52429;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_src_cpu = 1'b1, iv_src_cpu = 1'b1;
    logic [5:0] cpu_gate = '0, fab_gate = '0;
    logic cpu_gate_wr = 1'b0, cpu_iv_wr = 1'b0, cpu_u_rd = 1'b0;
    logic signed [31:0] cpu_udc = '0, cpu_ia = '0, cpu_ib = '0, cpu_ic = '0;
    logic signed [31:0] fab_udc = '0, fab_ia = '0, fab_ib = '0, fab_ic = '0;
    logic signed [31:0] u_ab, u_bc, u_ca, rd_u_ab, rd_u_bc, rd_u_ca;

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    inv3_voltage_model #(.DW(32), .FRAC(16), .RON_Q(RON), .VF_Q(VF)) dut_i (
        .clk(clk), .rst_n(rst_n), .gate_src_cpu(gate_src_cpu), .iv_src_cpu(iv_src_cpu),
        .cpu_gate(cpu_gate), .cpu_gate_wr(cpu_gate_wr),
        .cpu_udc(cpu_udc), .cpu_ia(cpu_ia), .cpu_ib(cpu_ib), .cpu_ic(cpu_ic), .cpu_iv_wr(cpu_iv_wr),
        .fab_gate(fab_gate), .fab_udc(fab_udc), .fab_ia(fab_ia), .fab_ib(fab_ib), .fab_ic(fab_ic),
        .cpu_u_rd(cpu_u_rd), .u_ab(u_ab), .u_bc(u_bc), .u_ca(u_ca),
        .rd_u_ab(rd_u_ab), .rd_u_bc(rd_u_bc), .rd_u_ca(rd_u_ca)
    );

    // Reference node voltage per leg, from the requirements.
    function automatic longint node_ref(bit t, bit b, longint udc, longint i);
        longint d = (longint'(RON) * i) >>> 16;
        if (t && !b) return udc - d;
        if (!t && b) return -d;
        if (t && b)  return (udc >>> 1) - d;
        if (i > 0)   return -longint'(VF);
        if (i < 0)   return udc + longint'(VF);
        return udc >>> 1;
    endfunction

    // Model state.
    logic [5:0] m_gate = '0;
    longint     m_udc = 0, m_i[3] = '{0, 0, 0};
    longint     e_u[3] = '{0, 0, 0}, e_rd[3] = '{0, 0, 0};

    always @(posedge clk) begin
        logic [5:0] g;
        longint udc, i[3], v[3];
        if (!rst_n) begin
            m_gate = '0; m_udc = 0; m_i = '{0, 0, 0};
            e_u = '{0, 0, 0}; e_rd = '{0, 0, 0};
        end else begin
            g   = gate_src_cpu ? m_gate : fab_gate;
            udc = iv_src_cpu ? m_udc : longint'(fab_udc);
            i[0] = iv_src_cpu ? m_i[0] : longint'(fab_ia);
            i[1] = iv_src_cpu ? m_i[1] : longint'(fab_ib);
            i[2] = iv_src_cpu ? m_i[2] : longint'(fab_ic);
            for (int k = 0; k < 3; k++) v[k] = node_ref(g[2*k], g[2*k+1], udc, i[k]);
            if (cpu_u_rd) e_rd = e_u;
            e_u[0] = v[0] - v[1];
            e_u[1] = v[1] - v[2];
            e_u[2] = v[2] - v[0];
            if (cpu_gate_wr) m_gate = cpu_gate;
            if (cpu_iv_wr) begin
                m_udc = cpu_udc; m_i[0] = cpu_ia; m_i[1] = cpu_ib; m_i[2] = cpu_ic;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, $signed(act), $signed(exp));
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (!done) begin
            chk(cur_req, "u_ab", u_ab, e_u[0][31:0]);
            chk(cur_req, "u_bc", u_bc, e_u[1][31:0]);
            chk(cur_req, "u_ca", u_ca, e_u[2][31:0]);
            chk("R12", "rd_u_ab", rd_u_ab, e_rd[0][31:0]);
            chk("R12", "rd_u_bc", rd_u_bc, e_rd[1][31:0]);
            chk("R12", "rd_u_ca", rd_u_ca, e_rd[2][31:0]);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_iv(input longint udc, input longint a, input longint b, input longint c);
        cpu_udc = 32'(udc); cpu_ia = 32'(a); cpu_ib = 32'(b); cpu_ic = 32'(c);
        cpu_iv_wr = 1'b1; cyc(1); cpu_iv_wr = 1'b0;
    endtask

    task automatic put_gate(input logic [5:0] g);
        cpu_gate = g; cpu_gate_wr = 1'b1; cyc(1); cpu_gate_wr = 1'b0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed = 7;
        longint d10 = (longint'(RON) * 10 * ONE) >>> 16;
        cyc(3);
        // R1: zero outputs in and right after reset
        chk("R1", "u_ab reset", u_ab, 0);
        chk("R1", "rd_u_ca reset", rd_u_ca, 0);
        rst_n = 1'b1;
        cyc(2);
        chk("R1", "u_bc after reset with zero committed values", u_bc, 0);

        // R2/R3: a top, b bottom, c bottom, 560 V, 10 A each
        cur_req = "R2";
        put_gate(6'b101001);
        put_iv(560 * ONE, 10 * ONE, 10 * ONE, 10 * ONE);
        cyc(1);
        chk("R2", "u_ab top vs bottom", u_ab, 560 * ONE);
        chk("R3", "u_bc two bottoms", u_bc, 0);
        chk("R3", "u_ca", u_ca, -560 * ONE);
        put_iv(560 * ONE, 10 * ONE, -20 * ONE, 10 * ONE);
        cyc(1);
        chk("R2", "u_ab unequal currents", u_ab, 32'(560 * ONE - d10 - 2 * d10));

        // R11: unstrobed processor writes have no effect
        cur_req = "R11";
        cpu_gate = 6'b010110; cpu_udc = 100 * ONE; cpu_ia = 0;
        cyc(4);
        chk("R11", "u_ab unchanged without strobe", u_ab, 32'(560 * ONE - 3 * d10));

        // R7: zero currents give exact Udc difference
        cur_req = "R7";
        put_gate(6'b101001);
        put_iv(560 * ONE, 0, 0, 0);
        cyc(1);
        chk("R7", "u_ab equals Udc", u_ab, 560 * ONE);

        // R4/R5: all off, diode by current sign, midpoint at zero current
        cur_req = "R4";
        put_gate(6'b000000);
        put_iv(560 * ONE, 10 * ONE, -10 * ONE, 0);
        cyc(1);
        chk("R4", "u_ab lower vs upper diode", u_ab, 32'(-longint'(VF) - (560 * ONE + longint'(VF))));
        chk("R5", "u_ca midpoint minus lower diode", u_ca, 32'(280 * ONE + longint'(VF)));

        // R6: shoot-through on leg a, leg b low
        cur_req = "R6";
        put_gate(6'b001011);
        put_iv(560 * ONE, 10 * ONE, 0, 0);
        cyc(1);
        chk("R6", "u_ab shoot-through", u_ab, 32'(280 * ONE - d10));

        // R12: capture then hold
        cpu_u_rd = 1'b1; cyc(1); cpu_u_rd = 1'b0;
        cyc(1);
        chk("R12", "rd_u_ab captured", rd_u_ab, 32'(280 * ONE - d10));
        put_gate(6'b100110);
        cyc(2);
        chk("R12", "rd_u_ab held", rd_u_ab, 32'(280 * ONE - d10));

        // R9/R10: fabric gates with processor currents, then both fabric
        cur_req = "R9";
        gate_src_cpu = 1'b0;
        for (int k = 0; k < 64; k++) begin
            fab_gate = 6'(k);
            cyc(1);
        end
        cur_req = "R10";
        iv_src_cpu = 1'b0;
        gate_src_cpu = 1'b1;
        for (int k = 0; k < 200; k++) begin
            seed = seed * 1103515245 + 12345;
            fab_ia = (seed >>> 4) % (100 * ONE);
            seed = seed * 1103515245 + 12345;
            fab_ib = (seed >>> 4) % (100 * ONE);
            fab_ic = (k % 5 == 0) ? 0 : -fab_ia;
            fab_udc = (400 + k) * ONE;
            if (k % 3 == 0) fab_gate = 6'(k * 7);
            if (k % 7 == 0) gate_src_cpu = ~gate_src_cpu;
            cpu_u_rd = (k % 11 == 0);
            cyc(1);
        end
        cpu_u_rd = 1'b0;

        // R8: one-cycle latency on a single fabric change
        cur_req = "R8";
        gate_src_cpu = 1'b0; fab_gate = 6'b011001;
        fab_udc = 300 * ONE; fab_ia = 0; fab_ib = 0; fab_ic = 0;
        cyc(2);
        fab_gate = 6'b100110;
        @(posedge clk); #1;
        chk("R8", "u_ab after one edge", u_ab, -300 * ONE);
        cyc(3);
        finish_run();
    end
endmodule